// File: doc/BRIEF.md
# DS3 Receive Alarm Interrupt Controller

This block sits behind a DS3 receive framer and turns its per-frame alarm qualifiers into software-visible state. Once per frame the framer pulses a strobe together with level indications for AIS, LOS, the idle pattern, out-of-frame, FERF and AIC. The block keeps a registered copy of each alarm and flags a change-of-state event whenever a level differs from its stored value. Each event is flagged in both directions, on declaration and on clearing. P-bit and CP-bit parity error pulses are single events and can arrive in any cycle.

Idle is not taken directly from the framer. A run counter declares idle only after 63 consecutive idle frames, and any frame without the pattern breaks the run. Events from enabled sources are latched into an interrupt status register that clears when it is read. An active-low interrupt request is driven while any enabled latched bit is set. An event only says that something changed, not which way, so software reads the live status register to learn the present state. While AIS is declared and the automatic option is on, an outgoing FERF request is raised without software help.

Top module: `ds3_rx_alarm_irq`

## Requirements
- R1: `irq_n` is low exactly while at least one interrupt status bit is set whose enable bit is also set; otherwise it is high.
- R2: AIS, LOS, OOF, FERF and AIC are sampled on each `frame_stb`. A sampled value that differs from the stored one, whether declared or cleared, sets that source's status bit at the same clock edge.
- R3: Idle is declared on the 63rd consecutive frame carrying the idle pattern and cleared on the first frame without it. Further idle frames after declaration cause no new event. Both the declaration and the clearing set the idle status bit.
- R4: Interrupt status register (address 3) bit positions: 7 CP-bit error, 6 LOS, 5 AIS, 4 idle, 3 FERF, 2 AIC, 1 OOF, 0 P-bit error. The interrupt enable register (address 2) uses the same positions.
- R5: Reading address 3 returns the latched bits and clears them at that read. Writes to address 3 have no effect.
- R6: The live status register (address 0) is read-only: bit 7 AIS, bit 6 LOS, bit 5 idle, bit 4 OOF, bits 3..0 read 0.
- R7: `ferf_req` is high while AIS is declared and the auto-FERF enable (address 1, bit 0) is 1.
- R8: A source whose enable bit is 0 sets no status bit, and an already set bit whose enable is 0 does not pull `irq_n` low.
- R9: An enabled event in the same cycle as a status read leaves its bit set after the read. The read returns the value the bits had before that cycle.
- R10: After reset all status bits and enables are 0, auto-FERF is 1, `irq_n` is high and `ferf_req` is low.
- R11: `p_err` and `cp_err` pulses set status bits 0 and 7 in any cycle, without needing `frame_stb`.
- R12: Read data appears on `reg_rdata` one clock after the cycle in which `reg_rd` is high, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One-cycle pulse per received frame |
| ais_in | input | 1 | AIS qualifier for this frame |
| los_in | input | 1 | LOS qualifier for this frame |
| idle_pat_in | input | 1 | Frame carries the idle pattern |
| oof_in | input | 1 | Out-of-frame qualifier |
| ferf_in | input | 1 | Received FERF indication |
| aic_in | input | 1 | Received AIC indication |
| p_err | input | 1 | P-bit parity error pulse |
| cp_err | input | 1 | CP-bit parity error pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| irq_n | output | 1 | Active-low interrupt request |
| ferf_req | output | 1 | Outgoing FERF request |

## Verification
An event caused by a frame or an error pulse lands in the status and live registers at the same rising edge that samples the stimulus. `irq_n` and `ferf_req` are decoded from those registers without further flops, so they are valid after that one edge. Read data follows one edge after the read strobe. The bench drives every input at a falling edge and samples one falling edge later, which is the first point where each result is due. A scoreboard queue holds the expected read data for each read. A monitor pops one entry at the falling edge after each read cycle, so results line up with the read that produced them, whatever tasks ran in between.

// File: rtl/ds3_alm_pkg.sv
package ds3_alm_pkg;
   localparam int REG_W     = 8;
   localparam int NUM_SRC   = 8;
   // interrupt status / enable bit positions
   localparam int ST_PERR   = 0;
   localparam int ST_OOF    = 1;
   localparam int ST_AIC    = 2;
   localparam int ST_FERF   = 3;
   localparam int ST_IDLE   = 4;
   localparam int ST_AIS    = 5;
   localparam int ST_LOS    = 6;
   localparam int ST_CPERR  = 7;
   // live status bit positions
   localparam int LV_OOF    = 4;
   localparam int LV_IDLE   = 5;
   localparam int LV_LOS    = 6;
   localparam int LV_AIS    = 7;
   // index of each level alarm inside the sampled vector
   localparam int LA_AIS    = 0;
   localparam int LA_LOS    = 1;
   localparam int LA_OOF    = 2;
   localparam int LA_FERF   = 3;
   localparam int LA_AIC    = 4;
   localparam int NUM_LVL   = 5;
   // register addresses
   localparam int A_LIVE    = 0;
   localparam int A_CTRL    = 1;
   localparam int A_IEN     = 2;
   localparam int A_ISTAT   = 3;
endpackage

// File: rtl/ds3_level_alarms.sv
module ds3_level_alarms #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         frame_stb,
   input  logic [N-1:0] lvl_in,
   output logic [N-1:0] lvl_q,
   output logic [N-1:0] chg
);
   if (N < 1) begin : g_bad_n
      $error("ds3_level_alarms: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_alarm
      logic q;
      always_ff @(posedge clk) begin
         if (!rst_n)         q <= 1'b0;
         else if (frame_stb) q <= lvl_in[i];
      end
      assign lvl_q[i] = q;
      assign chg[i]   = frame_stb & (lvl_in[i] ^ q);

      // R2: a strobed sample is what the stored level holds afterwards
      a_r2_level_tracks: assert property (@(posedge clk) disable iff (!rst_n)
         frame_stb |=> (q == $past(lvl_in[i])));
   end
endmodule

// File: rtl/ds3_idle_run.sv
module ds3_idle_run #(
   parameter int RUN = 63
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_stb,
   input  logic idle_pat,
   output logic idle_lvl,
   output logic idle_chg
);
   localparam int CW = $clog2(RUN + 1);
   localparam logic [CW-1:0] RUN_V = CW'(RUN);

   if (RUN < 1) begin : g_bad_run
      $error("ds3_idle_run: RUN must be at least 1");
   end

   logic [CW-1:0] cnt, cnt_nxt;

   always_comb begin
      cnt_nxt = cnt;
      if (frame_stb) begin
         if (!idle_pat)         cnt_nxt = '0;
         else if (cnt != RUN_V) cnt_nxt = cnt + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_nxt;
   end

   assign idle_lvl = (cnt == RUN_V);
   assign idle_chg = (cnt_nxt == RUN_V) ^ idle_lvl;

   a_r3_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= RUN_V);
   a_r3_decl_needs_idle_frame: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(idle_lvl) |-> $past(frame_stb && idle_pat));
   a_r3_break_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb && !idle_pat) |=> !idle_lvl);
endmodule

// File: rtl/ds3_irq_status.sv
module ds3_irq_status #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] ev,
   input  logic [N-1:0] en,
   input  logic         clr,
   output logic [N-1:0] st,
   output logic         irq_n
);
   logic [N-1:0] hit;
   assign hit = ev & en;

   always_ff @(posedge clk) begin
      if (!rst_n) st <= '0;
      else        st <= (clr ? '0 : st) | hit;
   end

   assign irq_n = ~|(st & en);

   a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && hit == '0) |=> (st == '0));
   a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> ((st & $past(hit)) == $past(hit)));
   a_r8_only_enabled_set: assert property (@(posedge clk) disable iff (!rst_n)
      ((st & ~$past(st) & ~$past(en)) == '0));
endmodule

// File: rtl/ds3_rx_alarm_irq.sv
module ds3_rx_alarm_irq
   import ds3_alm_pkg::*;
#(
   parameter int ADDR_W      = 2,
   parameter int IDLE_FRAMES = 63,
   parameter bit AUTO_FERF_RST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_stb,
   input  logic              ais_in,
   input  logic              los_in,
   input  logic              idle_pat_in,
   input  logic              oof_in,
   input  logic              ferf_in,
   input  logic              aic_in,
   input  logic              p_err,
   input  logic              cp_err,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              irq_n,
   output logic              ferf_req
);
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ds3_rx_alarm_irq: ADDR_W must be at least 2");
   end

   localparam logic [ADDR_W-1:0] AD_LIVE  = ADDR_W'(A_LIVE);
   localparam logic [ADDR_W-1:0] AD_CTRL  = ADDR_W'(A_CTRL);
   localparam logic [ADDR_W-1:0] AD_IEN   = ADDR_W'(A_IEN);
   localparam logic [ADDR_W-1:0] AD_ISTAT = ADDR_W'(A_ISTAT);

   // level alarms
   logic [NUM_LVL-1:0] lvl_in, lvl_q, lvl_chg;
   always_comb begin
      lvl_in          = '0;
      lvl_in[LA_AIS]  = ais_in;
      lvl_in[LA_LOS]  = los_in;
      lvl_in[LA_OOF]  = oof_in;
      lvl_in[LA_FERF] = ferf_in;
      lvl_in[LA_AIC]  = aic_in;
   end

   ds3_level_alarms #(.N(NUM_LVL)) u_lvl (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_stb (frame_stb),
      .lvl_in    (lvl_in),
      .lvl_q     (lvl_q),
      .chg       (lvl_chg)
   );

   logic idle_lvl, idle_chg;
   ds3_idle_run #(.RUN(IDLE_FRAMES)) u_idle (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_stb (frame_stb),
      .idle_pat  (idle_pat_in),
      .idle_lvl  (idle_lvl),
      .idle_chg  (idle_chg)
   );

   // configuration registers
   logic             auto_ferf;
   logic [REG_W-1:0] ien;
   logic             wr_ctrl, wr_ien, rd_stat;

   assign wr_ctrl = reg_wr && (reg_addr == AD_CTRL);
   assign wr_ien  = reg_wr && (reg_addr == AD_IEN);
   assign rd_stat = reg_rd && (reg_addr == AD_ISTAT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         auto_ferf <= AUTO_FERF_RST;
         ien       <= '0;
      end else begin
         if (wr_ctrl) auto_ferf <= reg_wdata[0];
         if (wr_ien)  ien       <= reg_wdata;
      end
   end

   // event vector in status bit order
   logic [NUM_SRC-1:0] ev;
   always_comb begin
      ev           = '0;
      ev[ST_PERR]  = p_err;
      ev[ST_OOF]   = lvl_chg[LA_OOF];
      ev[ST_AIC]   = lvl_chg[LA_AIC];
      ev[ST_FERF]  = lvl_chg[LA_FERF];
      ev[ST_IDLE]  = idle_chg;
      ev[ST_AIS]   = lvl_chg[LA_AIS];
      ev[ST_LOS]   = lvl_chg[LA_LOS];
      ev[ST_CPERR] = cp_err;
   end

   logic [NUM_SRC-1:0] istat;
   ds3_irq_status #(.N(NUM_SRC)) u_stat (
      .clk   (clk),
      .rst_n (rst_n),
      .ev    (ev),
      .en    (ien),
      .clr   (rd_stat),
      .st    (istat),
      .irq_n (irq_n)
   );

   // live status and read mux
   logic [REG_W-1:0] live, rd_mux;
   always_comb begin
      live          = '0;
      live[LV_AIS]  = lvl_q[LA_AIS];
      live[LV_LOS]  = lvl_q[LA_LOS];
      live[LV_IDLE] = idle_lvl;
      live[LV_OOF]  = lvl_q[LA_OOF];
   end

   always_comb begin
      rd_mux = '0;
      if (reg_addr == AD_LIVE)       rd_mux = live;
      else if (reg_addr == AD_CTRL)  rd_mux = {{(REG_W-1){1'b0}}, auto_ferf};
      else if (reg_addr == AD_IEN)   rd_mux = ien;
      else if (reg_addr == AD_ISTAT) rd_mux = istat;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      reg_rdata <= '0;
      else if (reg_rd) reg_rdata <= rd_mux;
   end

   assign ferf_req = auto_ferf & lvl_q[LA_AIS];

   // R1: an enabled event raises the request on the next cycle
   a_r1_event_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(ev & ien)) && !wr_ien) |=> !irq_n);
   // R2: an AIS change with its source enabled latches bit 5
   a_r2_ais_change_latched: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb && (ais_in != lvl_q[LA_AIS]) && ien[ST_AIS]) |=> istat[ST_AIS]);
   // R7: declared AIS with auto-FERF on drives the request
   a_r7_ferf_follows_ais: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb && ais_in && auto_ferf && !wr_ctrl) |=> ferf_req);
   // R12: read data holds between reads
   a_r12_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> $stable(reg_rdata));
endmodule

// File: tb/ds3_rx_alarm_irq_tb.sv
module ds3_rx_alarm_irq_tb;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_stb = 1'b0;
   logic       ais_in = 1'b0, los_in = 1'b0, idle_pat_in = 1'b0;
   logic       oof_in = 1'b0, ferf_in = 1'b0, aic_in = 1'b0;
   logic       p_err = 1'b0, cp_err = 1'b0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       irq_n, ferf_req;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic       rd_seen = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ds3_rx_alarm_irq u_dut (
      .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
      .ais_in(ais_in), .los_in(los_in), .idle_pat_in(idle_pat_in),
      .oof_in(oof_in), .ferf_in(ferf_in), .aic_in(aic_in),
      .p_err(p_err), .cp_err(cp_err),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_n(irq_n), .ferf_req(ferf_req)
   );

   // monitor: one scoreboard entry per read, due one edge later (R12)
   always @(posedge clk) rd_seen <= reg_rd;

   always @(negedge clk) begin
      if (rd_seen) begin
         logic [7:0] e;
         string      t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if (reg_rdata !== e) begin
            errors++;
            $display("FAIL %s: rdata actual %02h expected %02h", t, reg_rdata, e);
         end
      end
   end

   task automatic chk(input logic act, input logic exp, input string t);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0b expected %0b", t, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      exp_q.push_back(e); tag_q.push_back(t);
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic frame(input logic ais, input logic los, input logic idle,
                        input logic oof, input logic ferf, input logic aic);
      @(negedge clk);
      frame_stb = 1'b1; ais_in = ais; los_in = los; idle_pat_in = idle;
      oof_in = oof; ferf_in = ferf; aic_in = aic;
      @(negedge clk);
      frame_stb = 1'b0;
   endtask

   task automatic pulse_err(input logic p, input logic cp);
      @(negedge clk);
      p_err = p; cp_err = cp;
      @(negedge clk);
      p_err = 1'b0; cp_err = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk(irq_n, 1'b1, "R10 irq_n after reset");
      chk(ferf_req, 1'b0, "R10 ferf_req after reset");
      rd(2'd3, 8'h00, "R10 status after reset");
      rd(2'd2, 8'h00, "R10 enables after reset");
      rd(2'd1, 8'h01, "R10 auto-FERF after reset");
      rd(2'd0, 8'h00, "R10 live after reset");
      wr(2'd2, 8'hFF);

      // AIS declare / clear
      frame(1, 0, 0, 0, 0, 0);
      chk(irq_n, 1'b0, "R1 irq_n low on AIS event");
      chk(ferf_req, 1'b1, "R7 ferf_req with AIS");
      rd(2'd0, 8'h80, "R6 live AIS bit 7");
      rd(2'd3, 8'h20, "R2 R4 AIS declare bit 5");
      chk(irq_n, 1'b1, "R1 irq_n high after read");
      rd(2'd3, 8'h00, "R5 status cleared by read");
      frame(0, 0, 0, 0, 0, 0);
      rd(2'd3, 8'h20, "R2 AIS clear sets bit 5");
      chk(ferf_req, 1'b0, "R7 ferf_req drops with AIS");
      rd(2'd0, 8'h00, "R6 live after AIS clear");

      // LOS, OOF, FERF, AIC together
      frame(0, 1, 0, 1, 1, 1);
      rd(2'd0, 8'h50, "R6 live LOS bit 6 OOF bit 4");
      rd(2'd3, 8'h4E, "R2 R4 LOS OOF FERF AIC declare");
      frame(0, 0, 0, 0, 0, 0);
      rd(2'd3, 8'h4E, "R2 LOS OOF FERF AIC clear");

      // parity error pulses
      pulse_err(1, 0);
      rd(2'd3, 8'h01, "R11 P-bit error bit 0");
      pulse_err(0, 1);
      rd(2'd3, 8'h80, "R11 CP-bit error bit 7");

      // idle run
      repeat (62) frame(0, 0, 1, 0, 0, 0);
      rd(2'd3, 8'h00, "R3 no idle after 62 frames");
      rd(2'd0, 8'h00, "R3 live idle low after 62 frames");
      frame(0, 0, 1, 0, 0, 0);
      rd(2'd3, 8'h10, "R3 idle declared on 63rd frame");
      rd(2'd0, 8'h20, "R6 live idle bit 5");
      repeat (5) frame(0, 0, 1, 0, 0, 0);
      rd(2'd3, 8'h00, "R3 no event while idle persists");
      rd(2'd0, 8'h20, "R3 idle stays declared");
      frame(0, 0, 0, 0, 0, 0);
      rd(2'd3, 8'h10, "R3 idle clear event");
      rd(2'd0, 8'h00, "R3 idle cleared");
      repeat (62) frame(0, 0, 1, 0, 0, 0);
      frame(0, 0, 0, 0, 0, 0);
      repeat (2) frame(0, 0, 1, 0, 0, 0);
      rd(2'd3, 8'h00, "R3 broken run never declares");

      // disabled source
      wr(2'd2, 8'hDF);
      frame(1, 0, 0, 0, 0, 0);
      chk(irq_n, 1'b1, "R8 disabled AIS keeps irq_n high");
      chk(ferf_req, 1'b1, "R7 ferf_req independent of enable");
      rd(2'd3, 8'h00, "R8 disabled AIS sets no bit");
      frame(0, 0, 0, 0, 0, 0);
      rd(2'd3, 8'h00, "R8 disabled AIS clear sets no bit");
      wr(2'd2, 8'hFF);
      pulse_err(1, 0);
      wr(2'd2, 8'hFE);
      chk(irq_n, 1'b1, "R8 masked set bit releases irq_n");
      wr(2'd2, 8'hFF);
      chk(irq_n, 1'b0, "R1 unmasked set bit drives irq_n");
      rd(2'd3, 8'h01, "R8 masked bit retained");

      // event in the same cycle as a status read
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = 2'd3; p_err = 1'b1;
      exp_q.push_back(8'h00); tag_q.push_back("R9 read returns pre-event value");
      @(negedge clk);
      reg_rd = 1'b0; p_err = 1'b0;
      chk(irq_n, 1'b0, "R9 irq_n stays low after colliding read");
      rd(2'd3, 8'h01, "R9 colliding event kept");

      // auto-FERF enable
      wr(2'd1, 8'h00);
      frame(1, 0, 0, 0, 0, 0);
      chk(ferf_req, 1'b0, "R7 auto-FERF off");
      rd(2'd3, 8'h20, "R2 AIS event with auto-FERF off");
      wr(2'd1, 8'h01);
      chk(ferf_req, 1'b1, "R7 auto-FERF re-enabled");
      frame(0, 0, 0, 0, 0, 0);
      chk(ferf_req, 1'b0, "R7 ferf_req withdrawn");
      rd(2'd3, 8'h20, "R2 AIS clear after re-enable");

      // writes to read-only registers
      pulse_err(1, 0);
      wr(2'd3, 8'h00);
      wr(2'd0, 8'hFF);
      rd(2'd3, 8'h01, "R5 write to status ignored");
      rd(2'd0, 8'h00, "R6 live register read-only");

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         checks++; errors++;
         $display("FAIL R12: actual %0d reads pending expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule